// File: doc/BRIEF.md
# I2C Target Register Block

This block lets a processor answer on an I2C bus as a 7-bit addressed target. It filters and synchronises the open-drain SCL and SDA lines, watches for START and STOP, compares the first byte of every transfer with a programmed own address, and acknowledges a match. After that it either collects bytes written by the bus controller or sends bytes that software supplies. Each step shows up as a bit in a status register, and any status bit that is enabled raises a single interrupt line.

Software paces the transfer. After each received byte, and before each byte it must send, the block holds SCL low. It releases SCL once software has cleared the matching status bit, which it does by writing a zero to it. A control bit makes the block answer a received byte with NACK instead of ACK. The transmit-mode status bit records whether the last matched address asked for a read or a write.

The register port is a plain strobe bus. A write happens in the cycle `bus_wr` is high. Read data appears on `bus_rdata` in the cycle after `bus_rd`.

Top module: `i2c_target_regs`

## Requirements
- R1: After reset the control (offset 0), status (offset 1), interrupt-enable (offset 2) and own-address (offset 3) registers read 0, `irq` is low, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: When the interface is enabled (control bit 2), an address byte whose upper seven bits equal the own-address register is acknowledged. The block acknowledges by driving SDA low during the ninth clock. A match sets status bit 0 (address received). Any other address is not acknowledged and sets no status bit other than the stop bit.
- R3: Address byte 0x00 (general call) is acknowledged only while control bit 1 is set. When it is acknowledged it sets status bits 6 and 0.
- R4: In a write transfer each received byte sets status bit 1 and can be read at offset 4 while control bit 3 is 0. SCL is held low until software clears status bit 1, and the byte is then acknowledged.
- R5: If control bit 0 is set when status bit 1 is cleared, the block answers that byte with NACK. It then ignores the rest of the transfer: no further status bits are set and the stored byte is kept.
- R6: A matching address with R/W=1 sets status bits 0, 5 and 3. SCL is held low until status bit 3 is cleared. The byte written to offset 4 is then shifted out MSB first. A controller ACK sets bits 2 and 3 and stretches again. A controller NACK sets only bit 2.
- R7: A STOP seen while enabled sets status bit 4 and returns the block to idle from any state, including mid-byte. The next START is decoded normally.
- R8: Writing a status bit with 0 clears it. Writing it with 1 leaves it unchanged.
- R9: `irq` is high one cycle after any status bit is set whose interrupt-enable bit (same position) is set. It is low when the enable register is 0.
- R10: While control bit 2 is 0, SDA and SCL are never driven and no status bit is set.
- R11: With control bit 3 set, a read of offset 4 returns the transmit byte last written instead of the last received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Random 7-bit own addresses are paired with random write-direction address bytes, about half of them forced to match. This separates the compare of the upper seven bits from decoding of the R/W bit and from the general-call path. Random data bytes in both directions show whether bit order and byte storage are right. Directed cases cover a STOP in the middle of a byte, a forced NACK followed by a byte the block should ignore, a controller NACK that ends a read, and a transfer on a disabled interface. In each case the check is that the block neither drives a line nor latches state it should not.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // status bit positions (interrupt enables share them)
  localparam int B_ADDR  = 0;
  localparam int B_RCVD  = 1;
  localparam int B_SENT  = 2;
  localparam int B_EMPTY = 3;
  localparam int B_STOP  = 4;
  localparam int B_TMODE = 5;
  localparam int B_GCALL = 6;
  localparam int STAT_W  = 7;

  // control bit positions
  localparam int C_FNACK  = 0;
  localparam int C_GCEN   = 1;
  localparam int C_EN     = 2;
  localparam int C_BUFSEL = 3;
  localparam int CTRL_W   = 4;

  // register offsets
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_IEN  = 2;
  localparam int A_OWN  = 3;
  localparam int A_DATA = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RXB,
    ST_RXWAIT,
    ST_RACK,
    ST_TXWAIT,
    ST_TXB,
    ST_TACK
  } tgt_state_e;

  // event pulses, packed in status bit order
  typedef struct packed {
    logic gcall;
    logic rd;
    logic stop;
    logic empty;
    logic sent;
    logic rcvd;
    logic addr;
  } tgt_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          gc_en,
  input  logic          fnack,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] tx_byte,
  input  logic          hold_rx,
  input  logic          hold_tx,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output tgt_ev_t       ev,
  output logic [DW-1:0] rx_byte,
  output logic          scl_oe,
  output logic          sda_oe
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          arm, rw, nack_q;
  logic          own_hit, gc_hit;

  assign own_hit = (sh[DW-1:1] == own_addr);
  assign gc_hit  = gc_en && (sh == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rx_byte <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      ev      <= '0;
      arm     <= 1'b0;
      rw      <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      ev <= '0;
      if (!en) begin
        state  <= ST_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        arm    <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        scl_oe  <= 1'b0;
        sda_oe  <= 1'b0;
        arm     <= 1'b0;
        ev.stop <= 1'b1;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        arm    <= 1'b0;
      end else begin
        arm <= 1'b0;
        unique case (state)
          ST_IDLE: begin
          end
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (own_hit || gc_hit) begin
                ev.addr  <= 1'b1;
                ev.gcall <= gc_hit;
                ev.rd    <= sh[0];
                rw       <= sh[0];
                sda_oe   <= 1'b1;
                state    <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (rw) begin
                scl_oe   <= 1'b1;
                arm      <= 1'b1;
                ev.empty <= 1'b1;
                state    <= ST_TXWAIT;
              end else begin
                state <= ST_RXB;
              end
            end
          end
          ST_RXB: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              rx_byte <= sh;
              ev.rcvd <= 1'b1;
              scl_oe  <= 1'b1;
              arm     <= 1'b1;
              state   <= ST_RXWAIT;
            end
          end
          ST_RXWAIT: begin
            if (!arm && !hold_rx) begin
              scl_oe <= 1'b0;
              sda_oe <= !fnack;
              nack_q <= fnack;
              state  <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= nack_q ? ST_IDLE : ST_RXB;
            end
          end
          ST_TXWAIT: begin
            if (!arm && !hold_tx) begin
              sh     <= tx_byte;
              sda_oe <= !tx_byte[DW-1];
              scl_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_TXB;
            end
          end
          ST_TXB: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_TACK;
              end else begin
                sda_oe <= !sh[DW-2];
                sh     <= {sh[DW-2:0], 1'b0};
              end
              cnt <= cnt + 1'b1;
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              ev.sent <= 1'b1;
              if (!nack_q) begin
                ev.empty <= 1'b1;
                scl_oe   <= 1'b1;
                arm      <= 1'b1;
                state    <= ST_TXWAIT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  en_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sda_oe && !scl_oe));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && stop_det) |=> (state == ST_IDLE && !scl_oe && !sda_oe));

  // R4
  rx_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_RXWAIT && !arm && hold_rx) |=> scl_oe);

endmodule

// File: rtl/i2c_tgt_csr.sv
module i2c_tgt_csr
  import i2c_tgt_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 7,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [RAW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq,
  input  tgt_ev_t        ev,
  input  logic [DW-1:0]  rx_byte,
  output logic           en,
  output logic           gc_en,
  output logic           fnack,
  output logic [AW-1:0]  own_addr,
  output logic [DW-1:0]  tx_byte,
  output logic           hold_rx,
  output logic           hold_tx
);

  localparam int SW = STAT_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [SW-1:0]     stat_q, ien_q, set_v, stat_d;
  logic [AW-1:0]     own_q;
  logic [DW-1:0]     tx_q;
  logic              wr_stat;

  assign wr_stat = bus_wr && (bus_addr == RAW'(A_STAT));

  always_comb begin
    set_v          = ev;
    set_v[B_TMODE] = ev.addr & ev.rd;
    stat_d         = stat_q;
    if (wr_stat) stat_d = stat_q & bus_wdata[SW-1:0];
    if (ev.addr && !ev.rd) stat_d[B_TMODE] = 1'b0;
    stat_d = stat_d | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      ien_q     <= '0;
      own_q     <= '0;
      tx_q      <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq    <= |(stat_q & ien_q);
      if (bus_wr) begin
        if (bus_addr == RAW'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
        if (bus_addr == RAW'(A_IEN))  ien_q  <= bus_wdata[SW-1:0];
        if (bus_addr == RAW'(A_OWN))  own_q  <= bus_wdata[AW-1:0];
        if (bus_addr == RAW'(A_DATA)) tx_q   <= bus_wdata;
      end
      if (bus_rd) begin
        if (bus_addr == RAW'(A_CTRL))      bus_rdata <= DW'(ctrl_q);
        else if (bus_addr == RAW'(A_STAT)) bus_rdata <= DW'(stat_q);
        else if (bus_addr == RAW'(A_IEN))  bus_rdata <= DW'(ien_q);
        else if (bus_addr == RAW'(A_OWN))  bus_rdata <= DW'(own_q);
        else if (bus_addr == RAW'(A_DATA)) bus_rdata <= ctrl_q[C_BUFSEL] ? tx_q : rx_byte;
        else                               bus_rdata <= '0;
      end
    end
  end

  assign en       = ctrl_q[C_EN];
  assign gc_en    = ctrl_q[C_GCEN];
  assign fnack    = ctrl_q[C_FNACK];
  assign own_addr = own_q;
  assign tx_byte  = tx_q;
  assign hold_rx  = stat_q[B_RCVD];
  assign hold_tx  = stat_q[B_EMPTY];

  // R8
  wr0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((stat_q & ~$past(bus_wdata[SW-1:0]) & ~$past(set_v)) == '0));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);

  // R6
  tmode_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.addr && ev.rd) |=> stat_q[B_TMODE]);

  // R3
  gcall_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ev.gcall |=> (stat_q[B_GCALL] && stat_q[B_ADDR]));

endmodule

// File: rtl/i2c_target_regs.sv
module i2c_target_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int RAW         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [RAW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq,
  input  logic           scl_i,
  output logic           scl_oe,
  input  logic           sda_i,
  output logic           sda_oe
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          en, gc_en, fnack, hold_rx, hold_tx;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] tx_byte, rx_byte;
  tgt_ev_t       ev;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .gc_en     (gc_en),
    .fnack     (fnack),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .hold_rx   (hold_rx),
    .hold_tx   (hold_tx),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ev        (ev),
    .rx_byte   (rx_byte),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  i2c_tgt_csr #(.DW(DW), .AW(AW), .RAW(RAW)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ev        (ev),
    .rx_byte   (rx_byte),
    .en        (en),
    .gc_en     (gc_en),
    .fnack     (fnack),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .hold_rx   (hold_rx),
    .hold_tx   (hold_tx)
  );

  // scl_s is kept for observability of the filtered line
  logic unused_scl;
  assign unused_scl = scl_s;

endmodule

// File: tb/i2c_target_regs_test.sv
module i2c_target_regs_test;

  localparam int HP = 10;
  localparam int A_CTRL = 0, A_STAT = 1, A_IEN = 2, A_OWN = 3, A_DATA = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       tb_scl = 1'b1, tb_sda = 1'b1;
  logic       scl_line, sda_line;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit dis_mon = 0, dis_drove = 0;
  logic [7:0] ctrl_cur = 8'h00;

  always #5 clk = ~clk;

  assign scl_line = tb_scl & ~scl_oe;
  assign sda_line = tb_sda & ~sda_oe;

  i2c_target_regs uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(posedge clk) if (dis_mon && (sda_oe || scl_oe)) dis_drove <= 1'b1;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hp(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(int a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic csr_rd(int a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(logic [7:0] v);
    ctrl_cur = v;
    csr_wr(A_CTRL, v);
  endtask

  task automatic wait_scl_high();
    int t = 0;
    while (!scl_line && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic m_start();
    tb_sda = 1'b1; hp(HP);
    tb_scl = 1'b1; wait_scl_high(); hp(HP);
    tb_sda = 1'b0; hp(HP);
    tb_scl = 1'b0; hp(HP);
  endtask

  task automatic m_stop();
    tb_sda = 1'b0; hp(HP);
    tb_scl = 1'b1; wait_scl_high(); hp(HP);
    tb_sda = 1'b1; hp(HP);
  endtask

  task automatic m_bit_out(logic b);
    tb_sda = b; hp(HP);
    tb_scl = 1'b1; wait_scl_high(); hp(HP);
    tb_scl = 1'b0; hp(3);
  endtask

  task automatic m_bit_in(output logic b);
    tb_sda = 1'b1; hp(HP);
    tb_scl = 1'b1; wait_scl_high(); hp(HP/2);
    b = sda_line; hp(HP/2);
    tb_scl = 1'b0; hp(3);
  endtask

  task automatic m_addr(logic [7:0] a, output logic ack_n);
    for (int i = 7; i >= 0; i--) m_bit_out(a[i]);
    m_bit_in(ack_n);
  endtask

  // write one byte that the target is expected to accept and stretch on
  task automatic m_wr_byte(logic [7:0] d, bit set_fn, string req, output logic ack_n);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    tb_sda = 1'b1; hp(HP);
    tb_scl = 1'b1; hp(40);
    check("R4", "scl stretched after byte", int'(scl_line), 0);
    csr_rd(A_STAT, r);
    check(req, "status after byte", r, 8'h02);
    csr_rd(A_DATA, r);
    check("R4", "received byte", r, d);
    if (set_fn) csr_wr(A_CTRL, ctrl_cur | 8'h01);
    csr_wr(A_STAT, 8'h7D);
    wait_scl_high(); hp(HP/2);
    ack_n = sda_line; hp(HP/2);
    tb_scl = 1'b0; hp(3);
  endtask

  task automatic m_rd_byte(logic [7:0] load, logic nack, output logic [7:0] got);
    logic [7:0] r;
    tb_sda = 1'b1; hp(HP);
    tb_scl = 1'b1; hp(40);
    check("R6", "scl stretched before tx byte", int'(scl_line), 0);
    csr_rd(A_STAT, r);
    check("R6", "empty flag before load", int'(r[3]), 1);
    csr_wr(A_DATA, load);
    csr_wr(A_STAT, 8'h73);
    wait_scl_high(); hp(HP/2);
    got[7] = sda_line; hp(HP/2);
    tb_scl = 1'b0; hp(3);
    for (int i = 6; i >= 0; i--) m_bit_in(got[i]);
    m_bit_out(nack);
  endtask

  function automatic logic exp_ack_n(logic [7:0] a, logic [6:0] own, bit en, bit gc);
    return !(en && ((a[7:1] == own) || (gc && a == 8'h00)));
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d, got, t2, fn_byte, a;
    logic [6:0] own;
    logic       ack;
    void'($urandom(32'h5EED));
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hp(2);

    // R1 reset state
    csr_rd(A_CTRL, r); check("R1", "ctrl", r, 0);
    csr_rd(A_STAT, r); check("R1", "status", r, 0);
    csr_rd(A_IEN, r);  check("R1", "irq enable", r, 0);
    csr_rd(A_OWN, r);  check("R1", "own address", r, 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "line drive", int'({scl_oe, sda_oe}), 0);

    csr_wr(A_OWN, 8'h3A);
    set_ctrl(8'h04);
    csr_wr(A_IEN, 8'h7F);

    // R2 / R4 / R9 write transfer
    m_start();
    m_addr(8'h74, ack);
    check("R2", "ack on own address", int'(ack), 0);
    hp(HP);
    csr_rd(A_STAT, r); check("R2", "address flag", r, 8'h01);
    check("R9", "irq raised", int'(irq), 1);
    csr_wr(A_STAT, 8'h00);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      m_wr_byte(d, 0, "R4", ack);
      check("R4", "byte acknowledged", int'(ack), 0);
    end
    m_stop(); hp(HP);
    csr_rd(A_STAT, r); check("R7", "stop flag", r, 8'h10);

    // R9 masking
    csr_wr(A_IEN, 8'h00); hp(2);
    check("R9", "irq masked", int'(irq), 0);
    csr_wr(A_IEN, 8'h10); hp(2);
    check("R9", "irq on stop enable", int'(irq), 1);
    csr_wr(A_IEN, 8'h7F);

    // R8 write-zero clear
    csr_wr(A_STAT, 8'h7F);
    csr_rd(A_STAT, r); check("R8", "write one keeps", r, 8'h10);
    csr_wr(A_STAT, 8'h6F);
    csr_rd(A_STAT, r); check("R8", "write zero clears", r, 8'h00);

    // R5 forced NACK
    m_start();
    m_addr(8'h74, ack);
    check("R5", "address ack", int'(ack), 0);
    hp(HP); csr_wr(A_STAT, 8'h00);
    fn_byte = 8'($urandom);
    m_wr_byte(fn_byte, 1, "R5", ack);
    check("R5", "forced nack", int'(ack), 1);
    d = ~fn_byte;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(ack);
    check("R5", "following byte not acked", int'(ack), 1);
    hp(HP);
    csr_rd(A_STAT, r); check("R5", "no status after nack", r, 8'h00);
    m_stop(); hp(HP);
    set_ctrl(8'h04);
    csr_wr(A_STAT, 8'h00);

    // R2 random addresses, write direction
    for (int k = 0; k < 8; k++) begin
      own = 7'($urandom_range(1, 127));
      csr_wr(A_OWN, {1'b0, own});
      a = ($urandom_range(0, 1) == 1) ? {own, 1'b0} : {7'($urandom), 1'b0};
      m_start();
      m_addr(a, ack);
      check("R2", "random address ack", int'(ack), int'(exp_ack_n(a, own, 1'b1, 1'b0)));
      m_stop(); hp(HP);
      csr_rd(A_STAT, r);
      check("R2", "random address status", r & 8'h6F,
            exp_ack_n(a, own, 1'b1, 1'b0) ? 0 : 8'h01);
      csr_wr(A_STAT, 8'h00);
    end
    csr_wr(A_OWN, 8'h3A);

    // R3 general call
    m_start(); m_addr(8'h00, ack);
    check("R3", "general call ignored when off", int'(ack), 1);
    m_stop(); hp(HP);
    csr_rd(A_STAT, r); check("R3", "no flags when off", r & 8'h6F, 0);
    set_ctrl(8'h06);
    csr_wr(A_STAT, 8'h00);
    m_start(); m_addr(8'h00, ack);
    check("R3", "general call acked", int'(ack), 0);
    hp(HP);
    csr_rd(A_STAT, r); check("R3", "general call flags", r, 8'h41);
    m_stop(); hp(HP);
    set_ctrl(8'h04);
    csr_wr(A_STAT, 8'h00);

    // R6 read transfer
    m_start(); m_addr(8'h75, ack);
    check("R6", "read address ack", int'(ack), 0);
    hp(HP);
    csr_rd(A_STAT, r); check("R6", "read match flags", r, 8'h29);
    csr_wr(A_STAT, 8'h7E);
    m_rd_byte(8'hA5, 1'b0, got);
    check("R6", "first tx byte", got, 8'hA5);
    hp(HP);
    csr_rd(A_STAT, r); check("R6", "sent and empty after ack", r, 8'h2C);
    t2 = 8'($urandom);
    m_rd_byte(t2, 1'b1, got);
    check("R6", "second tx byte", got, t2);
    hp(HP);
    csr_rd(A_STAT, r); check("R6", "sent only after nack", r, 8'h24);

    // R11 buffer select
    set_ctrl(8'h0C);
    csr_rd(A_DATA, r); check("R11", "data port shows tx byte", r, t2);
    set_ctrl(8'h04);
    csr_rd(A_DATA, r); check("R11", "data port shows rx byte", r, fn_byte);
    m_stop(); hp(HP);
    csr_rd(A_STAT, r); check("R7", "stop after read", int'(r[4]), 1);
    csr_wr(A_STAT, 8'h00);

    // R7 stop in the middle of a byte
    m_start(); m_addr(8'h74, ack);
    hp(HP); csr_wr(A_STAT, 8'h00);
    m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1);
    m_stop(); hp(HP);
    csr_rd(A_STAT, r); check("R7", "mid-byte stop flag", r, 8'h10);
    check("R7", "scl released after stop", int'(scl_oe), 0);
    csr_wr(A_STAT, 8'h00);
    m_start(); m_addr(8'h74, ack);
    check("R7", "next transfer decoded", int'(ack), 0);
    m_stop(); hp(HP);
    csr_wr(A_STAT, 8'h00);

    // R10 disabled interface
    set_ctrl(8'h00);
    dis_mon = 1'b1;
    m_start(); m_addr(8'h74, ack);
    check("R10", "no ack when disabled", int'(ack), 1);
    d = 8'h5C;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(ack);
    check("R10", "no data ack when disabled", int'(ack), 1);
    m_stop(); hp(HP);
    dis_mon = 1'b0;
    csr_rd(A_STAT, r); check("R10", "no status when disabled", r, 0);
    check("R10", "lines never driven", int'(dis_drove), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule